// File: doc/BRIEF.md
# Four-Slot Pulse-Position Receive Frame Guard

This block sits behind the chip sampler of a fast infrared receiver that uses four-slot pulse-position modulation. It receives one decoded symbol at a time, as a 4-bit chip nibble with a valid strobe. From those symbols it follows the frame structure: it hunts for a preamble, stays locked while preambles repeat, and then matches the start flag. After that it turns single-pulse data symbols into bytes and watches for the closing stop flag.

Broken frames are reported in two ways. An abort is raised for any of these:
- two empty symbols in a row;
- one of the illegal two-pulse codes;
- a stop flag that goes wrong part way through.

A framing error is raised when the preamble is followed by something that is neither another preamble nor the start flag.

Each finished byte is held back by one byte. This lets the end of the frame, whether it is a clean stop or an abort, mark the last good byte as end-of-frame on its way out. Partial bytes are dropped. After any frame end, abort or framing error, the block goes back to hunting for a preamble.

Chip sampling, clock recovery, CRC checking and buffer storage belong to the neighbouring blocks.

Top module: `ppm4_frame_guard`

## Requirements
- R1: No byte, abort or framing error comes out until at least one full preamble (1000 0100 0010 0001) has been followed by the full start flag (0000 1100 0000 1100 0110 0000 0000 0110). Symbols received while hunting give no output.
- R2: Inside a frame, the data codes are 1000, 0100, 0010 and 0001, carrying dibits 0, 1, 2 and 3. Four dibits make one byte, and the first dibit lands in bits [1:0]. A byte comes out with `byte_eof`=0 one cycle after the fourth symbol of the next byte.
- R3: Inside a frame, two consecutive 0000 symbols give an abort pulse one cycle after the second one.
- R4: Inside a frame, any symbol other than a data code or the first stop-flag symbol gives an abort pulse. This covers 0011, 0101, 1001 and 1010.
- R5: After a 0000 inside a frame, the symbols are matched against the stop flag (0000 1100 0000 1100 0000 0110 0000 0110). A complete match emits the held byte with `byte_eof`=1 and no abort. Any mismatch aborts.
- R6: On an abort, the held byte is emitted with `byte_eof`=1 in the same cycle as `abort_pulse`. If no byte is held, `byte_valid` stays 0.
- R7: After an abort or a complete stop flag, a data symbol gives no byte until a new preamble and start flag have been received.
- R8: Once a preamble has been seen, a symbol that does not continue the preamble or the start flag gives a `frame_err` pulse one cycle later. The block then returns to hunting.
- R9: While `sym_valid` is low, the symbol input is ignored and all output strobes are 0.
- R10: After reset, all outputs are 0 and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol strobe |
| sym | input | 4 | Chip nibble, first chip in bit 3 |
| byte_valid | output | 1 | Byte strobe |
| byte_data | output | 8 | Received byte |
| byte_eof | output | 1 | Byte is the last of its frame |
| abort_pulse | output | 1 | Frame aborted |
| frame_err | output | 1 | Framing error after preamble |

## Verification
The assertions assume two things about the inputs:
- the symbol input is only looked at when `sym_valid` is high;
- the configured preamble and start flag begin with different symbols, so the position counter never leaves the pattern lengths.

The stimulus keeps to this by driving every symbol for exactly one strobed cycle, with idle gaps in which the nibble is scrambled. Frames are built only from the default patterns, plus deliberate single-symbol corruptions placed at chosen positions in the preamble, the start flag, the data and the stop flag.

// File: rtl/ppm4_guard_pkg.sv
package ppm4_guard_pkg;

    localparam int SYM_W   = 4;
    localparam int BYTE_W  = 8;
    localparam int DIBITS  = BYTE_W / 2;
    localparam int DCNT_W  = $clog2(DIBITS);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PREAM,
        ST_START,
        ST_DATA,
        ST_STOP
    } frame_state_e;

    typedef struct packed {
        logic       single;
        logic [1:0] dibit;
    } sym_info_t;

    function automatic sym_info_t decode_sym(input logic [SYM_W-1:0] s);
        sym_info_t r;
        r.single = 1'b1;
        unique case (s)
            4'b1000: r.dibit = 2'd0;
            4'b0100: r.dibit = 2'd1;
            4'b0010: r.dibit = 2'd2;
            4'b0001: r.dibit = 2'd3;
            default: begin
                r.single = 1'b0;
                r.dibit  = 2'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ppm4_sym_decode.sv
module ppm4_sym_decode
    import ppm4_guard_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output logic             single,
    output logic [1:0]       dibit
);
    sym_info_t info;

    always_comb begin
        info   = decode_sym(sym);
        single = info.single;
        dibit  = info.dibit;
    end
endmodule

// File: rtl/ppm4_frame_fsm.sv
module ppm4_frame_fsm
    import ppm4_guard_pkg::*;
#(
    parameter int                      PRE_LEN  = 4,
    parameter int                      FLAG_LEN = 8,
    parameter logic [PRE_LEN*4-1:0]    PRE_SEQ  = 16'h8421,
    parameter logic [FLAG_LEN*4-1:0]   START_SEQ = 32'h0C0C_6006,
    parameter logic [FLAG_LEN*4-1:0]   STOP_SEQ  = 32'h0C0C_0606
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym,
    input  logic             single,
    output logic             dibit_stb,
    output logic             flush,
    output logic             abort_o,
    output logic             ferr_o
);
    localparam int MAXLEN = (FLAG_LEN > PRE_LEN) ? FLAG_LEN : PRE_LEN;
    localparam int CW     = $clog2(MAXLEN) + 1;
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_LEN - 1);
    localparam logic [CW-1:0] FLAG_LAST = CW'(FLAG_LEN - 1);

    function automatic logic [3:0] pre_at(input logic [CW-1:0] i);
        return PRE_SEQ[4*(PRE_LEN-1-int'(i)) +: 4];
    endfunction
    function automatic logic [3:0] start_at(input logic [CW-1:0] i);
        return START_SEQ[4*(FLAG_LEN-1-int'(i)) +: 4];
    endfunction
    function automatic logic [3:0] stop_at(input logic [CW-1:0] i);
        return STOP_SEQ[4*(FLAG_LEN-1-int'(i)) +: 4];
    endfunction

    frame_state_e state, nstate;
    logic [CW-1:0] pos, npos;
    logic          ab, fe;

    always_comb begin
        nstate    = state;
        npos      = pos;
        dibit_stb = 1'b0;
        flush     = 1'b0;
        ab        = 1'b0;
        fe        = 1'b0;
        if (sym_valid) begin
            unique case (state)
                ST_HUNT: begin
                    if (sym == pre_at(pos)) begin
                        if (pos == PRE_LAST) begin
                            nstate = ST_PREAM;
                            npos   = '0;
                        end else begin
                            npos = pos + 1'b1;
                        end
                    end else begin
                        npos = (sym == pre_at('0)) ? CW'(1) : '0;
                    end
                end
                ST_PREAM: begin
                    if (pos == '0 && sym == start_at('0)) begin
                        nstate = ST_START;
                        npos   = CW'(1);
                    end else if (sym == pre_at(pos)) begin
                        npos = (pos == PRE_LAST) ? '0 : pos + 1'b1;
                    end else begin
                        fe = 1'b1;
                    end
                end
                ST_START: begin
                    if (sym == start_at(pos)) begin
                        if (pos == FLAG_LAST) begin
                            nstate = ST_DATA;
                            npos   = '0;
                        end else begin
                            npos = pos + 1'b1;
                        end
                    end else begin
                        fe = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (sym == stop_at('0)) begin
                        nstate = ST_STOP;
                        npos   = CW'(1);
                    end else if (single) begin
                        dibit_stb = 1'b1;
                    end else begin
                        ab = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (sym == stop_at(pos)) begin
                        if (pos == FLAG_LAST) begin
                            flush  = 1'b1;
                            nstate = ST_HUNT;
                            npos   = '0;
                        end else begin
                            npos = pos + 1'b1;
                        end
                    end else begin
                        ab = 1'b1;
                    end
                end
                default: nstate = ST_HUNT;
            endcase
            if (ab || fe) begin
                flush  = ab;
                nstate = ST_HUNT;
                npos   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            pos     <= '0;
            abort_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            state   <= nstate;
            pos     <= npos;
            abort_o <= ab;
            ferr_o  <= fe;
        end
    end

    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> state == ST_HUNT); // R7
    AST_FERR_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        ferr_o |-> state == ST_HUNT); // R8
    AST_DATA_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_START); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(state) && !abort_o && !ferr_o)); // R9
endmodule

// File: rtl/ppm4_byte_packer.sv
module ppm4_byte_packer
    import ppm4_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dibit_stb,
    input  logic [1:0]        dibit,
    input  logic              flush,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eof
);
    localparam logic [DCNT_W-1:0] DLAST = DCNT_W'(DIBITS - 1);

    logic [BYTE_W-1:0] sh, hold, nbyte;
    logic              hold_vld;
    logic [DCNT_W-1:0] cnt;

    assign nbyte = {dibit, sh[BYTE_W-1:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            hold      <= '0;
            hold_vld  <= 1'b0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            if (flush) begin
                out_valid <= hold_vld;
                out_eof   <= hold_vld;
                out_data  <= hold;
                hold_vld  <= 1'b0;
                cnt       <= '0;
            end else if (dibit_stb) begin
                sh  <= nbyte;
                cnt <= cnt + 1'b1;
                if (cnt == DLAST) begin
                    out_valid <= hold_vld;
                    out_data  <= hold;
                    hold      <= nbyte;
                    hold_vld  <= 1'b1;
                end
            end
        end
    end

    AST_EOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid); // R6
    AST_BYTE_NEEDS_DIBIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |-> $past(dibit_stb)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> !hold_vld); // R7
endmodule

// File: rtl/ppm4_frame_guard.sv
module ppm4_frame_guard
    import ppm4_guard_pkg::*;
#(
    parameter int                      PRE_LEN   = 4,
    parameter int                      FLAG_LEN  = 8,
    parameter logic [PRE_LEN*4-1:0]    PRE_SEQ   = 16'h8421,
    parameter logic [FLAG_LEN*4-1:0]   START_SEQ = 32'h0C0C_6006,
    parameter logic [FLAG_LEN*4-1:0]   STOP_SEQ  = 32'h0C0C_0606
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_eof,
    output logic              abort_pulse,
    output logic              frame_err
);
    logic       single, dibit_stb, flush;
    logic [1:0] dibit;

    ppm4_sym_decode u_dec (
        .sym    (sym),
        .single (single),
        .dibit  (dibit)
    );

    ppm4_frame_fsm #(
        .PRE_LEN   (PRE_LEN),
        .FLAG_LEN  (FLAG_LEN),
        .PRE_SEQ   (PRE_SEQ),
        .START_SEQ (START_SEQ),
        .STOP_SEQ  (STOP_SEQ)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym       (sym),
        .single    (single),
        .dibit_stb (dibit_stb),
        .flush     (flush),
        .abort_o   (abort_pulse),
        .ferr_o    (frame_err)
    );

    ppm4_byte_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .dibit_stb (dibit_stb),
        .dibit     (dibit),
        .flush     (flush),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .out_eof   (byte_eof)
    );

    AST_NO_ABORT_AND_FERR: assert property (@(posedge clk) disable iff (rst)
        !(abort_pulse && frame_err)); // R8
endmodule

// File: tb/ppm4_frame_guard_test.sv
`timescale 1ns/1ps
module ppm4_frame_guard_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [3:0] sym = 4'h0;
    logic       byte_valid, byte_eof, abort_pulse, frame_err;
    logic [7:0] byte_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [7:0] fb [8];
    logic       have;
    logic [7:0] last;

    always #2.5 clk = ~clk;

    ppm4_frame_guard uut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_eof(byte_eof),
        .abort_pulse(abort_pulse), .frame_err(frame_err)
    );

    function automatic logic [3:0] pre_sym(input int i);
        logic [15:0] p = 16'h8421;
        return p[4*(3-i) +: 4];
    endfunction
    function automatic logic [3:0] start_sym(input int i);
        logic [31:0] p = 32'h0C0C6006;
        return p[4*(7-i) +: 4];
    endfunction
    function automatic logic [3:0] stop_sym(input int i);
        logic [31:0] p = 32'h0C0C0606;
        return p[4*(7-i) +: 4];
    endfunction
    function automatic logic [3:0] dib_sym(input logic [1:0] d);
        return 4'b1000 >> d;
    endfunction
    function automatic logic [3:0] bad_code(input int k);
        case (k % 4)
            0: return 4'b0011;
            1: return 4'b1001;
            2: return 4'b1010;
            default: return 4'b0101;
        endcase
    endfunction

    task automatic chk(input string tag, input logic ev, input logic [7:0] ed,
                       input logic ee, input logic ea, input logic ef);
        nchk++;
        if (byte_valid !== ev || byte_eof !== ee || abort_pulse !== ea ||
            frame_err !== ef || (ev && byte_data !== ed)) begin
            nfail++;
            $display("FAIL %s: got v=%b d=%h eof=%b ab=%b fe=%b exp v=%b d=%h eof=%b ab=%b fe=%b",
                     tag, byte_valid, byte_data, byte_eof, abort_pulse, frame_err,
                     ev, ed, ee, ea, ef);
        end
    endtask

    task automatic send(input logic [3:0] s, input logic ev, input logic [7:0] ed,
                        input logic ee, input logic ea, input logic ef, input string tag);
        @(negedge clk);
        sym = s;
        sym_valid = 1'b1;
        @(negedge clk);
        chk(tag, ev, ed, ee, ea, ef);
        sym_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            sym = 4'($urandom);
            @(negedge clk);
            chk("R9 idle", 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic lead_in(input int npre);
        for (int p = 0; p < npre; p++)
            for (int i = 0; i < 4; i++) send(pre_sym(i), 0, 0, 0, 0, 0, "R1 preamble");
        for (int i = 0; i < 8; i++) send(start_sym(i), 0, 0, 0, 0, 0, "R1 start");
    endtask

    // term: 0 clean stop, 1 double empty, 2 illegal code, 3 stop mismatch at bad
    task automatic frame(input int npre, input int nb, input int npart,
                         input int term, input int bad);
        have = 1'b0;
        last = 8'h0;
        lead_in(npre);
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 4; k++) begin
                if (k == 3) begin
                    send(dib_sym(fb[b][2*k +: 2]), have, last, 1'b0, 0, 0, "R2 byte");
                    have = 1'b1;
                    last = fb[b];
                end else begin
                    send(dib_sym(fb[b][2*k +: 2]), 0, 0, 0, 0, 0, "R2 dibit");
                end
            end
        end
        for (int k = 0; k < npart; k++)
            send(dib_sym(2'($urandom)), 0, 0, 0, 0, 0, "R2 partial");
        case (term)
            0: for (int i = 0; i < 8; i++)
                   send(stop_sym(i), (i == 7) && have, last, (i == 7) && have, 0, 0, "R5 stop");
            1: begin
                send(4'b0000, 0, 0, 0, 0, 0, "R3 first empty");
                send(4'b0000, have, last, have, 1, 0, "R3 R6 double empty");
            end
            2: send(bad_code(bad), have, last, have, 1, 0, "R4 R6 illegal code");
            default: begin
                for (int i = 0; i < bad; i++) send(stop_sym(i), 0, 0, 0, 0, 0, "R5 stop prefix");
                send(stop_sym(bad) ^ 4'b0001, have, last, have, 1, 0, "R5 R6 stop mismatch");
            end
        endcase
        idle(int'($urandom % 3));
        send(4'b0100, 0, 0, 0, 0, 0, "R7 hunt after end");
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got no finish, exp finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        chk("R10 reset", 0, 0, 0, 0, 0);
        rst = 1'b0;
        idle(2);

        // R1: noise and data codes while hunting
        send(4'b0011, 0, 0, 0, 0, 0, "R1 hunt noise");
        send(4'b0100, 0, 0, 0, 0, 0, "R1 hunt data");
        send(4'b0000, 0, 0, 0, 0, 0, "R1 hunt empty");

        // R8: bad symbol after preamble, mid-preamble, mid-start
        for (int i = 0; i < 4; i++) send(pre_sym(i), 0, 0, 0, 0, 0, "R8 pre");
        send(4'b0010, 0, 0, 0, 0, 1, "R8 after preamble");
        send(4'b1000, 0, 0, 0, 0, 0, "R8 back in hunt");
        for (int i = 0; i < 4; i++) send(pre_sym(i), 0, 0, 0, 0, 0, "R8 pre");
        send(pre_sym(0), 0, 0, 0, 0, 0, "R8 pre repeat");
        send(pre_sym(1), 0, 0, 0, 0, 0, "R8 pre repeat");
        send(4'b1000, 0, 0, 0, 0, 1, "R8 mid preamble");
        for (int i = 0; i < 4; i++) send(pre_sym(i), 0, 0, 0, 0, 0, "R8 pre");
        for (int i = 0; i < 3; i++) send(start_sym(i), 0, 0, 0, 0, 0, "R8 start");
        send(4'b0001, 0, 0, 0, 0, 1, "R8 mid start");
        send(4'b0001, 0, 0, 0, 0, 0, "R8 hunt after error");

        // directed frames
        fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'hFF;
        frame(1, 3, 0, 0, 0);
        frame(2, 0, 0, 1, 0);
        frame(1, 1, 2, 2, 1);
        frame(1, 2, 3, 3, 1);
        frame(1, 2, 0, 3, 7);
        frame(3, 1, 0, 1, 0);

        // random frames
        for (int n = 0; n < 60; n++) begin
            for (int b = 0; b < 8; b++) fb[b] = 8'($urandom);
            frame(1 + int'($urandom % 3), int'($urandom % 6), int'($urandom % 4),
                  int'($urandom % 4), 1 + int'($urandom % 7));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule